// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar from a one-pulse-per-second tick. It holds seconds, minutes, hours, day of week, day of month, month, year and a 2-bit binary century field, all in packed BCD except the century. Month lengths and leap years are corrected by the block itself, and the century field takes part in the leap-year rule for year 00.

A host sets the clock by presenting all seven register bytes at once with a load strobe. The load also issues a one-cycle reset pulse to the upstream divider chain, so the next second starts fresh. A stop bit in the seconds byte halts timekeeping. While the host reads the registers it raises a hold input. The visible time then stays still, and a tick that arrives meanwhile is kept and applied when the hold drops.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the outputs read 00:00:00, day of week 1, date 01, month 01, year 00, century 0, stop bit 0, and `div_rst_o` low.
- R2: Seconds and minutes count 00 to 59 and hours 00 to 23 in packed BCD (high nibble tens, low nibble units). Each tick adds one second, and each roll-over carries into the next field in the same clock cycle.
- R3: Day of week sits in bits 2:0 of its byte and counts 1 to 7. It advances when hours roll from 23 to 00 and wraps from 7 to 1.
- R4: Date advances at the same midnight carry and rolls to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, after 30 in months 04, 06, 09 and 11, and after 28 or 29 in month 02.
- R5: February has 29 days when the BCD year divides by 4. The exception is year 00, which is a leap year only when the century field is 0.
- R6: Month counts 01 to 12 in bits 4:0 of the month byte and rolls to 01, carrying into the year. Year counts 00 to 99. Its roll from 99 to 00 adds one in binary to the century field in bits 7:6 of the month byte, and the century wraps from 3 to 0.
- R7: A load writes all seven bytes at the next clock edge. It overrides a tick in the same cycle and discards any pending tick. Bits outside a field read 0: minute bit 7, hour bits 7:6, day-of-week bits 7:3, date bits 7:6, month bit 5. `div_rst_o` is high for exactly the one cycle after each load.
- R8: Bit 7 of the seconds byte is the stop bit and is written by a load. While it is 1, ticks are ignored and no field changes.
- R9: While `hold_i` is high, no output changes except through a load. One tick seen during a hold is applied at the first clock edge with `hold_i` low. Further ticks in the same hold are dropped.
- R10: If a tick arrives in the same cycle the hold drops while a tick is pending, both are applied, on two consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per second |
| hold_i | input | 1 | Freeze visible time during a host read |
| load_i | input | 1 | Load strobe for all seven bytes |
| load_sec_i | input | 8 | Seconds byte to load, bit 7 is the stop bit |
| load_min_i | input | 8 | Minutes byte to load |
| load_hour_i | input | 8 | Hours byte to load |
| load_dow_i | input | 8 | Day-of-week byte to load |
| load_date_i | input | 8 | Date byte to load |
| load_month_i | input | 8 | Century (7:6) and month (4:0) to load |
| load_year_i | input | 8 | Year byte to load |
| sec_o | output | 8 | Stop bit and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours |
| dow_o | output | 8 | Day of week |
| date_o | output | 8 | BCD date |
| month_o | output | 8 | Century and BCD month |
| year_o | output | 8 | BCD year |
| div_rst_o | output | 1 | One-cycle divider reset after a load |

## Verification
The main stimulus is a set of loaded start times, each followed by one or a few ticks. Single-second steps check BCD units and tens. The 23:59:59 starts check the full carry chain into day of week, date, month, year and century. The February starts cover years 23, 24, 12, 10 and 96 and year 00 under two century values, which separates the divide-by-4 test on both tens parities from the century exception. Directed sequences then test the hold corners: one tick, two ticks, a release with a tick in the same cycle, and a load during a hold. They also test stop, masked loads, and a load that collides with a tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W  = 8;
  localparam int CENT_W = 2;

  function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
    return {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic leap_year(input logic [REG_W-1:0] yr,
                                     input logic [CENT_W-1:0] cent);
    logic div4;
    if (yr[4]) div4 = (yr[3:0] == 4'h2) || (yr[3:0] == 4'h6);
    else       div4 = (yr[3:0] == 4'h0) || (yr[3:0] == 4'h4) || (yr[3:0] == 4'h8);
    if (yr == '0) return (cent == '0);
    return div4;
  endfunction
endpackage

// File: rtl/rtc_tick_gate.sv
module rtc_tick_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hold_i,
  input  logic stop_i,
  input  logic load_i,
  output logic adv_o
);
  logic pend_q, pend_d;

  assign adv_o = !load_i && !stop_i && !hold_i && (tick_i || pend_q);

  always_comb begin
    if (load_i || stop_i) pend_d = 1'b0;
    else if (hold_i)      pend_d = pend_q || tick_i;
    else                  pend_d = pend_q && tick_i; // both present: one kept
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [REG_W-1:0] FIRST = '0,
  parameter logic [REG_W-1:0] MASK  = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [REG_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic [REG_W-1:0] last_i,
  output logic [REG_W-1:0] val_o,
  output logic             wrap_o
);
  logic [REG_W-1:0] val_q;

  assign wrap_o = step_i && (val_q >= last_i);
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     val_q <= FIRST;
    else if (load_i) val_q <= load_val_i & MASK;
    else if (step_i) val_q <= wrap_o ? FIRST : (bcd_inc(val_q) & MASK);
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  logic [REG_W-1:0]  month_i,
  input  logic [REG_W-1:0]  year_i,
  input  logic [CENT_W-1:0] cent_i,
  output logic [REG_W-1:0]  last_date_o
);
  always_comb begin
    unique case (month_i)
      8'h02:                      last_date_o = leap_year(year_i, cent_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
      default:                    last_date_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       load_i,
  input  logic [7:0] load_sec_i,
  input  logic [7:0] load_min_i,
  input  logic [7:0] load_hour_i,
  input  logic [7:0] load_dow_i,
  input  logic [7:0] load_date_i,
  input  logic [7:0] load_month_i,
  input  logic [7:0] load_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       div_rst_o
);
  localparam int NFIX = 3;
  localparam logic [REG_W-1:0] FIX_LAST [NFIX] = '{8'h59, 8'h59, 8'h23};
  localparam logic [REG_W-1:0] FIX_MASK [NFIX] = '{8'h7f, 8'h7f, 8'h3f};

  logic              stop_q, div_rst_q, adv;
  logic [CENT_W-1:0] cent_q;
  logic [REG_W-1:0]  fix_val [NFIX];
  logic [REG_W-1:0]  fix_ld  [NFIX];
  logic [NFIX-1:0]   fix_wrap, fix_step;
  logic [REG_W-1:0]  dow_val, date_val, month_val, year_val, last_date;
  logic              dow_wrap, date_wrap, month_wrap, year_wrap;

  rtc_tick_gate u_gate (
    .clk_i, .rst_ni, .tick_i, .hold_i,
    .stop_i(stop_q), .load_i, .adv_o(adv)
  );

  assign fix_ld[0] = load_sec_i;
  assign fix_ld[1] = load_min_i;
  assign fix_ld[2] = load_hour_i;
  assign fix_step  = {fix_wrap[NFIX-2:0], adv};

  // seconds -> minutes -> hours carry chain
  for (genvar i = 0; i < NFIX; i++) begin : g_fix
    rtc_bcd_field #(.FIRST(8'h00), .MASK(FIX_MASK[i])) u_fld (
      .clk_i, .rst_ni, .load_i,
      .load_val_i(fix_ld[i]), .step_i(fix_step[i]), .last_i(FIX_LAST[i]),
      .val_o(fix_val[i]), .wrap_o(fix_wrap[i])
    );
  end

  rtc_bcd_field #(.FIRST(8'h01), .MASK(8'h07)) u_dow (
    .clk_i, .rst_ni, .load_i, .load_val_i(load_dow_i),
    .step_i(fix_wrap[NFIX-1]), .last_i(8'h07),
    .val_o(dow_val), .wrap_o(dow_wrap)
  );

  rtc_month_len u_mlen (
    .month_i(month_val), .year_i(year_val), .cent_i(cent_q),
    .last_date_o(last_date)
  );

  rtc_bcd_field #(.FIRST(8'h01), .MASK(8'h3f)) u_date (
    .clk_i, .rst_ni, .load_i, .load_val_i(load_date_i),
    .step_i(fix_wrap[NFIX-1]), .last_i(last_date),
    .val_o(date_val), .wrap_o(date_wrap)
  );

  rtc_bcd_field #(.FIRST(8'h01), .MASK(8'h1f)) u_month (
    .clk_i, .rst_ni, .load_i, .load_val_i(load_month_i),
    .step_i(date_wrap), .last_i(8'h12),
    .val_o(month_val), .wrap_o(month_wrap)
  );

  rtc_bcd_field #(.FIRST(8'h00), .MASK(8'hff)) u_year (
    .clk_i, .rst_ni, .load_i, .load_val_i(load_year_i),
    .step_i(month_wrap), .last_i(8'h99),
    .val_o(year_val), .wrap_o(year_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cent_q    <= '0;
      stop_q    <= 1'b0;
      div_rst_q <= 1'b0;
    end else begin
      div_rst_q <= load_i;
      if (load_i) begin
        cent_q <= load_month_i[REG_W-1 -: CENT_W];
        stop_q <= load_sec_i[REG_W-1];
      end else if (year_wrap) begin
        cent_q <= cent_q + 1'b1;
      end
    end

  logic unused_wrap;
  assign unused_wrap = dow_wrap;

  assign sec_o     = {stop_q, fix_val[0][REG_W-2:0]};
  assign min_o     = fix_val[1];
  assign hour_o    = fix_val[2];
  assign dow_o     = dow_val;
  assign date_o    = date_val;
  assign month_o   = {cent_q, month_val[REG_W-CENT_W-1:0]};
  assign year_o    = year_val;
  assign div_rst_o = div_rst_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hold_i,
  input logic       load_i,
  input logic [7:0] load_sec_i,
  input logic [7:0] load_year_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       div_rst_o
);
  logic [55:0] tm;
  assign tm = {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};

  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !load_i |=> $stable(tm)); // R9

  AST_STOP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o[7] && !load_i |=> $stable(tm)); // R8

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> {sec_o, year_o} == $past({load_sec_i, load_year_i})); // R7

  AST_DIV_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> div_rst_o); // R7

  AST_DIV_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> !div_rst_o); // R7

  AST_MIN_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) && $past(sec_o[6:0]) == 7'h59 && sec_o[6:0] == 7'h00
    |-> min_o != $past(min_o)); // R2

  AST_CENT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) && month_o[7:6] != $past(month_o[7:6])
    |-> $past(year_o) == 8'h99 && year_o == 8'h00); // R6
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .load_i(load_i),
  .load_sec_i(load_sec_i), .load_year_i(load_year_i),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
  .date_o(date_o), .month_o(month_o), .year_o(year_o), .div_rst_o(div_rst_o)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, hold = 1'b0, load = 1'b0;
  logic [7:0] l_sec = 0, l_min = 0, l_hour = 0, l_dow = 0, l_date = 0, l_month = 0, l_year = 0;
  logic [7:0] sec, mn, hr, dow, date, month, year;
  logic div_rst;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_calendar u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .hold_i(hold), .load_i(load),
    .load_sec_i(l_sec), .load_min_i(l_min), .load_hour_i(l_hour), .load_dow_i(l_dow),
    .load_date_i(l_date), .load_month_i(l_month), .load_year_i(l_year),
    .sec_o(sec), .min_o(mn), .hour_o(hr), .dow_o(dow), .date_o(date),
    .month_o(month), .year_o(year), .div_rst_o(div_rst)
  );

  function automatic logic [55:0] now();
    return {sec, mn, hr, dow, date, month, year};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [55:0] v);
    @(negedge clk);
    {l_sec, l_min, l_hour, l_dow, l_date, l_month, l_year} = v;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  // {load bytes, tick count, expected bytes}, byte order sec min hour dow date month year
  localparam int NV = 22;
  localparam logic [119:0] VEC [NV] = '{
    {56'h00_00_00_01_01_01_00, 8'd1, 56'h01_00_00_01_01_01_00},
    {56'h59_00_00_01_01_01_00, 8'd1, 56'h00_01_00_01_01_01_00},
    {56'h59_59_09_02_05_03_21, 8'd1, 56'h00_00_10_02_05_03_21},
    {56'h58_00_00_01_01_01_00, 8'd3, 56'h01_01_00_01_01_01_00},
    {56'h19_37_14_05_17_08_42, 8'd1, 56'h20_37_14_05_17_08_42},
    {56'h59_59_23_07_31_12_99, 8'd1, 56'h00_00_00_01_01_41_00},
    {56'h59_59_23_03_28_02_24, 8'd1, 56'h00_00_00_04_29_02_24},
    {56'h59_59_23_03_28_02_23, 8'd1, 56'h00_00_00_04_01_03_23},
    {56'h59_59_23_03_29_02_24, 8'd1, 56'h00_00_00_04_01_03_24},
    {56'h59_59_23_03_28_02_00, 8'd1, 56'h00_00_00_04_29_02_00},
    {56'h59_59_23_03_28_42_00, 8'd1, 56'h00_00_00_04_01_43_00},
    {56'h59_59_23_03_28_02_12, 8'd1, 56'h00_00_00_04_29_02_12},
    {56'h59_59_23_03_28_82_96, 8'd1, 56'h00_00_00_04_29_82_96},
    {56'h59_59_23_03_28_02_10, 8'd1, 56'h00_00_00_04_01_03_10},
    {56'h59_59_23_03_30_04_25, 8'd1, 56'h00_00_00_04_01_05_25},
    {56'h59_59_23_03_30_06_25, 8'd1, 56'h00_00_00_04_01_07_25},
    {56'h59_59_23_03_30_09_25, 8'd1, 56'h00_00_00_04_01_10_25},
    {56'h59_59_23_03_30_11_25, 8'd1, 56'h00_00_00_04_01_12_25},
    {56'h59_59_23_03_30_01_25, 8'd1, 56'h00_00_00_04_31_01_25},
    {56'h59_59_23_03_31_01_25, 8'd1, 56'h00_00_00_04_01_02_25},
    {56'h59_59_23_03_31_12_25, 8'd1, 56'h00_00_00_04_01_01_26},
    {56'h59_59_23_06_31_D2_99, 8'd1, 56'h00_00_00_07_01_01_00}
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset time", {8'h0, now()}, {8'h0, 56'h00_00_00_01_01_01_00});
    check("R1 reset div_rst", {63'h0, div_rst}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i][119:64]);
      do_ticks(int'(VEC[i][63:56]));
      check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), {8'h0, now()}, {8'h0, VEC[i][55:0]});
    end

    // R7 masks and divider reset pulse
    do_load({7{8'hff}});
    check("R7 masked load", {8'h0, now()}, {8'h0, 56'hff_7f_3f_07_3f_df_ff});
    check("R7 div_rst after load", {63'h0, div_rst}, 64'h1);
    @(negedge clk);
    check("R7 div_rst one cycle", {63'h0, div_rst}, 64'h0);

    // R8 stop bit
    do_load(56'hA0_00_00_01_01_01_00);
    do_ticks(3);
    check("R8 stopped", {56'h0, sec}, {56'h0, 8'hA0});
    do_load(56'h20_00_00_01_01_01_00);
    do_ticks(1);
    check("R8 restarted", {56'h0, sec}, {56'h0, 8'h21});

    // R7 load wins over a tick in the same cycle
    @(negedge clk);
    {l_sec, l_min, l_hour, l_dow, l_date, l_month, l_year} = 56'h10_00_00_01_01_01_00;
    load = 1'b1; tick = 1'b1;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
    check("R7 load over tick", {56'h0, sec}, {56'h0, 8'h10});

    // R9 single pending tick
    @(negedge clk); hold = 1'b1;
    do_ticks(1);
    check("R9 frozen in hold", {56'h0, sec}, {56'h0, 8'h10});
    hold = 1'b0;
    @(negedge clk);
    check("R9 pending applied", {56'h0, sec}, {56'h0, 8'h11});

    // R9 second tick in a hold is dropped
    hold = 1'b1;
    do_ticks(2);
    hold = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 one pending only", {56'h0, sec}, {56'h0, 8'h12});

    // R10 release together with a fresh tick
    hold = 1'b1;
    do_ticks(1);
    hold = 1'b0; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R10 first step", {56'h0, sec}, {56'h0, 8'h13});
    @(negedge clk);
    check("R10 second step", {56'h0, sec}, {56'h0, 8'h14});

    // R7 load during hold discards pending tick
    hold = 1'b1;
    do_ticks(1);
    do_load(56'h30_00_00_01_01_01_00);
    hold = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 pending cleared by load", {56'h0, sec}, {56'h0, 8'h30});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule